// File: doc/BRIEF.md
# Bunch-Crossing Counter Synchroniser

This block keeps a local bunch-crossing number that advances by one every clock and wraps once per orbit of 3564 crossings. The local orbit marker is high whenever the count is zero. A resync command loads a programmable starting value into the count instead of zero. Software tunes this value until the local orbit marker lines up with the orbit marker that arrives over the link.

Each received orbit marker is compared with the local count. If the count is not zero, the block raises a one-clock mismatch pulse. It also sets an error level that stays up for at least the rest of that orbit. The block adds one to a saturating mismatch tally. A received marker that lands on a count of zero clears the error level. A resync or a hard reset clears both the level and the tally.

The compare logic is a small state machine with three states. ST_HUNT means no marker has been seen since resync or reset. ST_LOCKED means the last received marker matched. ST_SLIPPED means the last received marker did not match. The transitions are as follows. A resync moves any state to ST_HUNT. A matching marker moves any state to ST_LOCKED. A mismatching marker moves any state to ST_SLIPPED. With no marker and no resync, the state holds. The error level is high only in ST_SLIPPED.

Top module: `bxn_sync_top`

## Requirements
- R1: While hard reset is asserted, and in the first cycle after it, the outputs read as follows: count 0, local marker 1, mismatch pulse 0, error level 0, tally 0.
- R2: Without resync, the count increases by one per clock and goes from 3563 to 0. The local marker is 1 exactly when the count is 0.
- R3: When a resync is sampled, the count in the next cycle equals the 12-bit offset input. An offset of 3564 or more loads 3563 instead.
- R4: A received marker sampled while the count is not zero gives a mismatch pulse of one clock in the following cycle. A received marker at count 0 gives no pulse.
- R5: The error level goes to 1 together with a mismatch pulse. It stays unchanged in cycles with no received marker. It goes to 0 after a received marker sampled at count 0.
- R6: The tally is 16 bits wide. It increases by one on each mismatch and holds at 65535.
- R7: A resync clears the error level and the tally in the next cycle. A received marker sampled in the same cycle as a resync is ignored: it gives no pulse and does not change the tally.
- R8: When every received marker arrives at count 0, the pulse, the level and the tally all stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one cycle per bunch crossing |
| rst_i | input | 1 | Synchronous hard reset, active high |
| resync_i | input | 1 | Resync command pulse |
| bc0_rx_i | input | 1 | Orbit marker received over the link |
| offset_i | input | 12 | Count value loaded on resync |
| bxn_o | output | 12 | Local bunch-crossing number |
| local_bc0_o | output | 1 | Local orbit marker (count is zero) |
| bc0_err_o | output | 1 | One-cycle mismatch pulse |
| bxn_err_o | output | 1 | Orbit-long mismatch level |
| err_cnt_o | output | 16 | Saturating mismatch tally |

## Verification
The assertions assume that reset is synchronous. They also assume that resync and the received marker are plain single-cycle strobes, which may repeat or coincide. No rate or spacing limit is placed on these strobes. The random stimulus keeps to this. It draws markers and resyncs as independent sparse strobes and offsets over the full 12-bit range. The random runs therefore include clamped offsets, markers that coincide with a resync, and markers back to back. Directed runs cover the tuned case, an orbit-long error that clears on the next matching marker, and a stream of mismatches long enough to saturate the tally.

// File: rtl/bxs_pkg.sv
package bxs_pkg;

    // Orbit-compare state: nothing seen yet, last marker matched, last marker slipped
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_LOCKED  = 2'd1,
        ST_SLIPPED = 2'd2
    } bxs_state_e;

    localparam int unsigned BXS_ORBIT_DEFAULT = 3564;
    localparam int unsigned BXS_TALLY_DEFAULT = 16;

endpackage

// File: rtl/bxs_orbit_ctr.sv
module bxs_orbit_ctr #(
    parameter int unsigned ORBIT_LEN = bxs_pkg::BXS_ORBIT_DEFAULT,
    localparam int unsigned CNT_W    = $clog2(ORBIT_LEN)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] offset_i,
    output logic [CNT_W-1:0] bxn_o,
    output logic             at_zero_o
);
    localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(ORBIT_LEN - 1);
    localparam logic [CNT_W:0]   LIMIT_W = (CNT_W + 1)'(ORBIT_LEN);

    logic [CNT_W-1:0] bxn_q;
    logic [CNT_W-1:0] load_val;

    // offsets past the last valid crossing fold onto it
    always_comb begin
        if ({1'b0, offset_i} >= LIMIT_W) load_val = LAST_V;
        else                             load_val = offset_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)                 bxn_q <= '0;
        else if (load_i)           bxn_q <= load_val;
        else if (bxn_q == LAST_V)  bxn_q <= '0;
        else                       bxn_q <= bxn_q + 1'b1;
    end

    assign bxn_o     = bxn_q;
    assign at_zero_o = (bxn_q == '0);

    assert_wrap_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (bxn_q == LAST_V && !load_i) |=> (bxn_q == '0));

    assert_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (bxn_q != LAST_V && !load_i) |=> (bxn_q == $past(bxn_q) + 1'b1));

    assert_range_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (bxn_q <= LAST_V));

endmodule

// File: rtl/bxs_sync_fsm.sv
module bxs_sync_fsm
    import bxs_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic resync_i,
    input  logic bc0_rx_i,
    input  logic at_zero_i,
    output logic mismatch_o,
    output logic slip_pulse_o,
    output logic slip_level_o
);
    bxs_state_e state_q, state_d;

    assign mismatch_o = bc0_rx_i && !at_zero_i && !resync_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT, ST_LOCKED, ST_SLIPPED: begin
                if (resync_i)      state_d = ST_HUNT;
                else if (bc0_rx_i) state_d = at_zero_i ? ST_LOCKED : ST_SLIPPED;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_HUNT;
        else       state_q <= state_d;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) slip_pulse_o <= 1'b0;
        else       slip_pulse_o <= mismatch_o;
    end

    assign slip_level_o = (state_q == ST_SLIPPED);

    assert_pulse_cause_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        slip_pulse_o |-> ($past(bc0_rx_i) && !$past(at_zero_i) && !$past(resync_i)));

    assert_pulse_with_level_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        slip_pulse_o |-> slip_level_o);

    assert_level_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!bc0_rx_i && !resync_i) |=> $stable(slip_level_o));

    assert_match_clears_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (bc0_rx_i && at_zero_i && !resync_i) |=> !slip_level_o);

    assert_resync_clears_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        resync_i |=> (!slip_level_o && !slip_pulse_o));

endmodule

// File: rtl/bxs_err_acc.sv
module bxs_err_acc #(
    parameter int unsigned TALLY_W = bxs_pkg::BXS_TALLY_DEFAULT
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               clr_i,
    input  logic               inc_i,
    output logic [TALLY_W-1:0] tally_o
);
    localparam logic [TALLY_W-1:0] TOP_V = '1;

    logic [TALLY_W-1:0] tally_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i)               tally_q <= '0;
        else if (inc_i && tally_q != TOP_V) tally_q <= tally_q + 1'b1;
    end

    assign tally_o = tally_q;

    assert_saturate_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (tally_q == TOP_V && !clr_i) |=> (tally_q == TOP_V));

    assert_clear_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> (tally_q == '0));

    assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!inc_i && !clr_i) |=> $stable(tally_q));

endmodule

// File: rtl/bxn_sync_top.sv
module bxn_sync_top #(
    parameter int unsigned ORBIT_LEN = bxs_pkg::BXS_ORBIT_DEFAULT,
    parameter int unsigned TALLY_W   = bxs_pkg::BXS_TALLY_DEFAULT,
    localparam int unsigned CNT_W    = $clog2(ORBIT_LEN)
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               resync_i,
    input  logic               bc0_rx_i,
    input  logic [CNT_W-1:0]   offset_i,
    output logic [CNT_W-1:0]   bxn_o,
    output logic               local_bc0_o,
    output logic               bc0_err_o,
    output logic               bxn_err_o,
    output logic [TALLY_W-1:0] err_cnt_o
);
    logic at_zero;
    logic mismatch;

    bxs_orbit_ctr #(.ORBIT_LEN(ORBIT_LEN)) u_ctr (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .load_i    (resync_i),
        .offset_i  (offset_i),
        .bxn_o     (bxn_o),
        .at_zero_o (at_zero)
    );

    bxs_sync_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .resync_i     (resync_i),
        .bc0_rx_i     (bc0_rx_i),
        .at_zero_i    (at_zero),
        .mismatch_o   (mismatch),
        .slip_pulse_o (bc0_err_o),
        .slip_level_o (bxn_err_o)
    );

    bxs_err_acc #(.TALLY_W(TALLY_W)) u_acc (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clr_i   (resync_i),
        .inc_i   (mismatch),
        .tally_o (err_cnt_o)
    );

    assign local_bc0_o = at_zero;

    assert_tally_tracks_pulse_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (bc0_err_o && $past(err_cnt_o) != '1) |-> (err_cnt_o == $past(err_cnt_o) + 1'b1));

endmodule

// File: tb/sim_bxn_sync_top.sv
module sim_bxn_sync_top;

    localparam int ORBIT = 3564;
    localparam int LAST  = ORBIT - 1;

    logic        clk = 1'b0;
    logic        rst_i = 1'b1;
    logic        resync_i = 1'b0;
    logic        bc0_rx_i = 1'b0;
    logic [11:0] offset_i = '0;
    logic [11:0] bxn_o;
    logic        local_bc0_o, bc0_err_o, bxn_err_o;
    logic [15:0] err_cnt_o;

    int vectors = 0;
    int fails   = 0;

    // reference state
    int m_bxn = 0;
    bit m_pulse = 0;
    bit m_level = 0;
    int m_cnt = 0;

    always #5 clk = ~clk;

    bxn_sync_top u0 (
        .clk_i       (clk),
        .rst_i       (rst_i),
        .resync_i    (resync_i),
        .bc0_rx_i    (bc0_rx_i),
        .offset_i    (offset_i),
        .bxn_o       (bxn_o),
        .local_bc0_o (local_bc0_o),
        .bc0_err_o   (bc0_err_o),
        .bxn_err_o   (bxn_err_o),
        .err_cnt_o   (err_cnt_o)
    );

    function automatic int clamp_off(input int v);
        return (v >= ORBIT) ? LAST : v;
    endfunction

    task automatic compare(input string tag);
        vectors++;
        if (int'(bxn_o) != m_bxn || local_bc0_o != (m_bxn == 0) || bc0_err_o != m_pulse
            || bxn_err_o != m_level || int'(err_cnt_o) != m_cnt) begin
            fails++;
            $display("FAIL %s: got bxn=%0d bc0=%0b pulse=%0b level=%0b cnt=%0d, want bxn=%0d bc0=%0b pulse=%0b level=%0b cnt=%0d",
                     tag, bxn_o, local_bc0_o, bc0_err_o, bxn_err_o, err_cnt_o,
                     m_bxn, (m_bxn == 0), m_pulse, m_level, m_cnt);
        end
    endtask

    // drive at falling edge, advance the model, check at the next falling edge
    task automatic cycle(input bit rs, input bit b0, input int off, input string tag);
        resync_i = rs;
        bc0_rx_i = b0;
        offset_i = 12'(off);
        if (rs) begin
            m_bxn = clamp_off(off); m_pulse = 0; m_level = 0; m_cnt = 0;
        end else begin
            m_pulse = b0 && (m_bxn != 0);
            if (b0) m_level = (m_bxn != 0);
            if (m_pulse && m_cnt != 65535) m_cnt++;
            m_bxn = (m_bxn == LAST) ? 0 : m_bxn + 1;
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst_i = 1'b1; resync_i = 1'b0; bc0_rx_i = 1'b0;
        m_bxn = 0; m_pulse = 0; m_level = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 in reset");
        rst_i = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout, want completion");
        summary();
        $finish;
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'hB0C0_0451);
        @(negedge clk);
        do_reset();
        cycle(0, 0, 0, "R1 first cycle");

        // R2: free run through two wraps
        for (int i = 0; i < 2 * ORBIT + 10; i++) cycle(0, 0, 0, "R2 wrap");

        // R3: offset loads, including clamped values
        cycle(1, 0, 5, "R3 offset 5");
        cycle(0, 0, 0, "R3 after load");
        cycle(1, 0, LAST, "R3 offset max");
        cycle(0, 0, 0, "R2 wrap after max load");
        cycle(1, 0, ORBIT, "R3 offset 3564 clamps");
        cycle(1, 0, 4095, "R3 offset 4095 clamps");
        cycle(1, 0, 0, "R3 offset 0");

        // R8: tuned, every marker on count 0
        for (int i = 0; i < 3 * ORBIT; i++)
            cycle(0, (m_bxn == 0), 0, "R8 tuned");

        // R4/R5: one slipped marker, level holds for the orbit, then clears
        cycle(1, 0, 10, "R7 resync");
        while (m_bxn != 100) cycle(0, 0, 0, "R5 idle");
        cycle(0, 1, 0, "R4 mismatch pulse");
        cycle(0, 0, 0, "R4 pulse is one cycle");
        while (m_bxn != 0) cycle(0, 0, 0, "R5 level holds");
        cycle(0, 1, 0, "R5 match clears level");
        cycle(0, 0, 0, "R5 stays clear");

        // R7: marker together with resync is ignored
        while (m_bxn != 50) cycle(0, 0, 0, "R5 idle");
        cycle(0, 1, 0, "R4 second mismatch");
        cycle(1, 1, 200, "R7 resync wins over marker");
        cycle(0, 0, 0, "R7 cleared");

        // constrained random: sparse markers and resyncs, full-range offsets
        for (int i = 0; i < 20000; i++) begin
            bit rs, b0;
            rs = ($urandom % 400) == 0;
            b0 = ($urandom % 30) == 0;
            cycle(rs, b0, int'($urandom % 4096), "R4 R5 R7 random");
        end

        // R6: marker every cycle until the tally saturates
        cycle(1, 0, 0, "R7 resync before saturation");
        while (m_cnt < 65535) cycle(0, 1, 0, "R6 climbing");
        for (int i = 0; i < 40; i++) cycle(0, 1, 0, "R6 saturated");
        cycle(1, 0, 0, "R7 resync clears saturated tally");

        // R1: hard reset mid-run
        cycle(0, 1, 0, "R4 mismatch before reset");
        do_reset();
        cycle(0, 0, 0, "R1 after second reset");

        summary();
        $finish;
    end

endmodule